// File: doc/BRIEF.md
# Clock Source and Power-Mode Controller

This block decides where a small controller's CPU clock comes from and how fast it runs. It picks one of two oscillators, either the external oscillator or the on-chip ring oscillator, and divides that source by a ratio. The ratio depends on a 2-bit speed code and on which source is in use. Both oscillators are modelled as single-cycle tick inputs in the system clock domain. The CPU clock is a single-cycle enable pulse that fires on the divider's terminal count.

Software writes a mode byte to select the source, to switch the external oscillator on or off, and to set the speed. A fixed state graph decides which writes are legal. It only allows a switch to the external source after that oscillator has settled, and it never stops the oscillator that is driving the CPU. Wait and stop requests park the controller. In wait, the CPU clock is gated and the oscillators keep running. In stop, both oscillators are halted. A wake interrupt returns the controller to the run state it left.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After synchronous reset, `pm_state` reads 0 (on-chip source with the external oscillator running), both oscillator enables are 1, and the CPU clock is the on-chip tick divided by 8 (speed code 01).
- R2: With the on-chip source, speed code `mode_wdata[7:6]` gives these ratios: 00 gives /2, 01 gives /8, 10 gives /128 and 11 gives /1, counted in `ring_tick` pulses.
- R3: With the external source, the speed codes give these ratios: 00 gives /2, 01 gives /8, 10 gives /8 and 11 gives /1, counted in `xin_tick` pulses.
- R4: In mode writes, bit 3 selects the source (1 = on-chip, 0 = external) and bit 4 enables the external oscillator (1 = on). From state 0, a write with bit3=0 and bit4=1 while `xin_stable` is high moves to state 1 (external source).
- R5: While `xin_stable` is low, a write asking for the external source leaves the state at 0. The speed field of that write is still applied.
- R6: State 2 (on-chip source, external oscillator off, `xin_osc_en`=0) is entered only from state 0, by a write with bit3=1 and bit4=0. In state 2, writes with bit3=0 are rejected. In state 1, writes that clear bit 4 are rejected. A write with bit3=1 and bit4=1 returns state 1 or state 2 to state 0.
- R7: `wait_req` in a run state enters state 3 on the next cycle. In state 3, `cpu_clk_en` stays 0 and the oscillator enables keep their run values. `wake_irq` returns the controller to the saved run state on the next cycle.
- R8: `stop_req` in a run state enters state 4, which drives both oscillator enables to 0. `stop_req` takes priority over a simultaneous `wait_req`. `wake_irq` returns the controller to the saved run state.
- R9: A new ratio takes effect only at the divider's terminal count. The period in progress when a write arrives finishes at the old ratio and is never shortened.
- R10: Mode writes are ignored while in state 3 or state 4. A wait or stop request in the same cycle as a write takes priority, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte: [7:6] speed, [4] external enable, [3] source |
| wait_req | input | 1 | Enter wait mode |
| stop_req | input | 1 | Enter stop mode |
| wake_irq | input | 1 | Interrupt that leaves wait or stop |
| xin_stable | input | 1 | External oscillator has settled |
| xin_tick | input | 1 | External oscillator tick |
| ring_tick | input | 1 | On-chip oscillator tick |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| pm_state | output | 3 | 0 on-chip, 1 external, 2 on-chip with external off, 3 wait, 4 stop |
| xin_osc_en | output | 1 | External oscillator enable |
| ring_osc_en | output | 1 | On-chip oscillator enable |

## Verification
A wrong state shows up on `pm_state` and on the oscillator enables in the cycle right after the write, request or wake that caused it. A wrong saved state appears on the first cycle after wake. Errors in the ratio or in the divider count are slower to appear. They become visible at the next terminal count, which is up to 128 source ticks later, as a `cpu_clk_en` pulse that arrives early, arrives late or is missing. Because of this, the bench compares every output on every cycle against a behavioural model, and it also counts the pulses in windows of whole periods.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;

    localparam int REG_W   = 8;
    localparam int DIV_W   = 8;
    localparam int SPD_W   = 2;
    localparam int SPD_HI  = 7;
    localparam int SPD_LO  = 6;
    localparam int XEN_BIT = 4;
    localparam int SRC_BIT = 3;

    typedef logic [SPD_W-1:0] speed_t;
    typedef logic [DIV_W-1:0] ratio_t;

    typedef enum logic [2:0] {
        ST_RING = 3'd0,
        ST_EXT  = 3'd1,
        ST_XOFF = 3'd2,
        ST_WAIT = 3'd3,
        ST_STOP = 3'd4
    } pm_state_e;

    localparam speed_t SPD_HIGH   = 2'b00;
    localparam speed_t SPD_MIDDLE = 2'b01;
    localparam speed_t SPD_LOW    = 2'b10;
    localparam speed_t SPD_DOUBLE = 2'b11;

    function automatic logic is_run(pm_state_e s);
        return (s == ST_RING) || (s == ST_EXT) || (s == ST_XOFF);
    endfunction

    function automatic ratio_t div_ratio(logic on_ring, speed_t spd);
        ratio_t r;
        case (spd)
            SPD_HIGH:   r = ratio_t'(2);
            SPD_MIDDLE: r = ratio_t'(8);
            SPD_LOW:    r = on_ring ? ratio_t'(128) : ratio_t'(8);
            default:    r = ratio_t'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clk_pwr_fsm.sv
module clk_pwr_fsm
    import clk_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic             wake_irq,
    input  logic             xin_stable,
    output pm_state_e        state_q,
    output pm_state_e        run_state,
    output speed_t           spd_q,
    output logic             xin_en,
    output logic             ring_en
);
    pm_state_e save_q, state_d, save_d;
    speed_t    spd_d;
    logic      w_src_ring, w_xin_on;

    assign w_src_ring = wdata[SRC_BIT];
    assign w_xin_on   = wdata[XEN_BIT];

    function automatic pm_state_e write_target(pm_state_e cur, logic src_ring,
                                               logic xin_on, logic stable);
        pm_state_e t;
        t = cur;
        case (cur)
            ST_RING: begin
                if (!src_ring && xin_on && stable) t = ST_EXT;
                else if (src_ring && !xin_on)      t = ST_XOFF;
            end
            ST_EXT, ST_XOFF: begin
                if (src_ring && xin_on) t = ST_RING;
            end
            default: t = cur;
        endcase
        return t;
    endfunction

    always_comb begin
        state_d = state_q;
        save_d  = save_q;
        spd_d   = spd_q;
        if (is_run(state_q)) begin
            if (stop_req) begin
                save_d  = state_q;
                state_d = ST_STOP;
            end else if (wait_req) begin
                save_d  = state_q;
                state_d = ST_WAIT;
            end else if (wr) begin
                spd_d   = wdata[SPD_HI:SPD_LO];
                state_d = write_target(state_q, w_src_ring, w_xin_on, xin_stable);
            end
        end else if (wake_irq) begin
            state_d = save_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RING;
            save_q  <= ST_RING;
            spd_q   <= SPD_MIDDLE;
        end else begin
            state_q <= state_d;
            save_q  <= save_d;
            spd_q   <= spd_d;
        end
    end

    assign run_state = is_run(state_q) ? state_q : save_q;
    assign xin_en    = (state_q != ST_STOP) && (run_state != ST_XOFF);
    assign ring_en   = (state_q != ST_STOP);

    assert_stable_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RING && !xin_stable) |=> (state_q != ST_EXT));

    assert_xoff_origin_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXT) |=> (state_q != ST_XOFF));

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (is_run(state_q) && stop_req) |=> (state_q == ST_STOP && !xin_en && !ring_en));

    assert_wake_return_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && wake_irq) |=> (state_q == $past(save_q)));

    assert_idle_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        (!is_run(state_q)) |=> $stable(spd_q));

endmodule

// File: rtl/clk_pwr_div.sv
module clk_pwr_div
    import clk_pwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  ratio_t next_ratio,
    output logic   pulse
);
    ratio_t cnt_q, act_q;
    logic   at_term;

    assign at_term = (cnt_q == act_q - ratio_t'(1));
    assign pulse   = run && tick && at_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= ratio_t'(8);
        end else if (run && tick) begin
            if (at_term) begin
                cnt_q <= '0;
                act_q <= next_ratio;
            end else begin
                cnt_q <= cnt_q + ratio_t'(1);
            end
        end
    end

    assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!pulse) |=> $stable(act_q));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < act_q));

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
    import clk_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic [REG_W-1:0] mode_wdata,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic             wake_irq,
    input  logic             xin_stable,
    input  logic             xin_tick,
    input  logic             ring_tick,
    output logic             cpu_clk_en,
    output logic [2:0]       pm_state,
    output logic             xin_osc_en,
    output logic             ring_osc_en
);
    pm_state_e state_q, run_state;
    speed_t    spd_q;
    logic      on_ring, src_tick;
    logic      unused_mode_bits;

    assign unused_mode_bits = ^{mode_wdata[5], mode_wdata[2:0]};

    clk_pwr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr         (mode_wr),
        .wdata      (mode_wdata),
        .wait_req   (wait_req),
        .stop_req   (stop_req),
        .wake_irq   (wake_irq),
        .xin_stable (xin_stable),
        .state_q    (state_q),
        .run_state  (run_state),
        .spd_q      (spd_q),
        .xin_en     (xin_osc_en),
        .ring_en    (ring_osc_en)
    );

    assign on_ring  = (run_state != ST_EXT);
    assign src_tick = on_ring ? ring_tick : xin_tick;

    clk_pwr_div u_div (
        .clk        (clk),
        .rst        (rst),
        .run        (is_run(state_q)),
        .tick       (src_tick),
        .next_ratio (div_ratio(on_ring, spd_q)),
        .pulse      (cpu_clk_en)
    );

    assign pm_state = state_q;

    assert_gated_idle_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (pm_state <= 3'd2));

    assert_ext_needs_osc_R6: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd1) |-> xin_osc_en);

endmodule

// File: tb/clk_pwr_ctrl_test.sv
`timescale 1ns/1ps
module clk_pwr_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic       wait_req = 1'b0, stop_req = 1'b0, wake_irq = 1'b0;
    logic       xin_stable = 1'b0, xin_tick = 1'b0, ring_tick = 1'b0;
    logic       cpu_clk_en, xin_osc_en, ring_osc_en;
    logic [2:0] pm_state;

    integer checks = 0, failures = 0, cyc = 0;
    string  cur_req = "R1";
    bit     done = 1'b0;

    integer m_state, m_saved, m_speed, m_cnt, m_act;

    clk_pwr_ctrl uut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .wait_req(wait_req), .stop_req(stop_req), .wake_irq(wake_irq),
        .xin_stable(xin_stable), .xin_tick(xin_tick), .ring_tick(ring_tick),
        .cpu_clk_en(cpu_clk_en), .pm_state(pm_state),
        .xin_osc_en(xin_osc_en), .ring_osc_en(ring_osc_en)
    );

    always #4 clk = ~clk;

    function automatic integer ratio_of(bit ring, integer spd);
        case (spd)
            0: return 2;
            1: return 8;
            2: return ring ? 128 : 8;
            default: return 1;
        endcase
    endfunction

    task automatic chk(bit ok, string req, integer act, integer exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            ring_tick = (cyc % 3) != 2;
            xin_tick  = (cyc % 2) == 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, 0);
            finish_tb();
        end
    end

    // behavioural reference, compared every cycle
    always @(negedge clk) begin
        integer eff, nst, tk;
        bit run, e_en, e_x, e_r;
        if (rst) begin
            m_state = 0; m_saved = 0; m_speed = 1; m_cnt = 0; m_act = 8;
        end else begin
            eff  = (m_state >= 3) ? m_saved : m_state;
            run  = (m_state <= 2);
            tk   = (eff == 1) ? xin_tick : ring_tick;
            e_en = run && tk && (m_cnt == m_act - 1);
            e_x  = (m_state != 4) && (eff != 2);
            e_r  = (m_state != 4);
            chk(pm_state == m_state[2:0], cur_req, pm_state, m_state);
            chk(cpu_clk_en == e_en, cur_req, cpu_clk_en, e_en);
            chk(xin_osc_en == e_x, cur_req, xin_osc_en, e_x);
            chk(ring_osc_en == e_r, cur_req, ring_osc_en, e_r);
            if (run && tk) begin
                if (m_cnt == m_act - 1) begin
                    m_cnt = 0;
                    m_act = ratio_of(eff != 1, m_speed);
                end else m_cnt++;
            end
            if (run) begin
                if (stop_req) begin m_saved = m_state; m_state = 4; end
                else if (wait_req) begin m_saved = m_state; m_state = 3; end
                else if (mode_wr) begin
                    nst = m_state;
                    if (m_state == 0) begin
                        if (!mode_wdata[3] && mode_wdata[4] && xin_stable) nst = 1;
                        else if (mode_wdata[3] && !mode_wdata[4]) nst = 2;
                    end else if (mode_wdata[3] && mode_wdata[4]) nst = 0;
                    m_state = nst;
                    m_speed = mode_wdata[7:6];
                end
            end else if (wake_irq) m_state = m_saved;
        end
    end

    task automatic write_mode(logic [7:0] d);
        @(posedge clk); #1; mode_wr = 1'b1; mode_wdata = d;
        @(posedge clk); #1; mode_wr = 1'b0;
    endtask

    task automatic pulse_in(bit w, bit s, bit i);
        @(posedge clk); #1; wait_req = w; stop_req = s; wake_irq = i;
        @(posedge clk); #1; wait_req = 0; stop_req = 0; wake_irq = 0;
    endtask

    task automatic check_state(string req, integer st, bit xe, bit re);
        @(negedge clk);
        chk(pm_state == st[2:0], req, pm_state, st);
        chk(xin_osc_en == xe, req, xin_osc_en, xe);
        chk(ring_osc_en == re, req, ring_osc_en, re);
    endtask

    // aligns to a pulse, then expects exactly 4 pulses in 4*r source ticks
    task automatic measure(string req, integer r, bit use_xin);
        integer ticks, pulses;
        ticks = 0; pulses = 0;
        @(negedge clk);
        while (!cpu_clk_en) @(negedge clk);
        while (ticks < 4 * r) begin
            @(negedge clk);
            if (use_xin ? xin_tick : ring_tick) ticks++;
            if (cpu_clk_en) pulses++;
        end
        chk(pulses == 4 && cpu_clk_en, req, pulses, 4);
    endtask

    initial begin
        integer ticks, idle_pulses;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        cur_req = "R1";
        check_state("R1", 0, 1, 1);
        measure("R1", 8, 0);

        cur_req = "R2";
        write_mode(8'h18 | 8'h00); measure("R2", 2, 0);
        write_mode(8'h18 | 8'h80); measure("R2", 128, 0);
        write_mode(8'h18 | 8'hC0); measure("R2", 1, 0);
        write_mode(8'h18 | 8'h40); measure("R2", 8, 0);

        cur_req = "R9";
        write_mode(8'h18 | 8'h80); measure("R9", 128, 0);
        ticks = 0;
        fork
            write_mode(8'h18 | 8'hC0);
            begin
                @(negedge clk);
                if (ring_tick) ticks++;
                while (!cpu_clk_en) begin
                    @(negedge clk);
                    if (ring_tick) ticks++;
                end
            end
        join
        chk(ticks == 128, "R9", ticks, 128);
        measure("R9", 1, 0);

        cur_req = "R5";
        xin_stable = 1'b0;
        write_mode(8'h10 | 8'h00);
        check_state("R5", 0, 1, 1);
        measure("R5", 2, 0);

        cur_req = "R4";
        xin_stable = 1'b1;
        write_mode(8'h10 | 8'h00);
        check_state("R4", 1, 1, 1);
        measure("R4", 2, 1);

        cur_req = "R3";
        write_mode(8'h10 | 8'h80); measure("R3", 8, 1);
        write_mode(8'h10 | 8'hC0); measure("R3", 1, 1);
        write_mode(8'h10 | 8'h40); measure("R3", 8, 1);

        cur_req = "R6";
        write_mode(8'h08 | 8'h40); check_state("R6", 1, 1, 1);
        write_mode(8'h00 | 8'h40); check_state("R6", 1, 1, 1);
        write_mode(8'h18 | 8'h40); check_state("R6", 0, 1, 1);
        write_mode(8'h08 | 8'h40); check_state("R6", 2, 0, 1);
        write_mode(8'h10 | 8'h40); check_state("R6", 2, 0, 1);
        measure("R6", 8, 0);

        cur_req = "R7";
        pulse_in(1, 0, 0);
        check_state("R7", 3, 0, 1);
        idle_pulses = 0;
        repeat (20) begin
            @(negedge clk);
            if (cpu_clk_en) idle_pulses++;
        end
        chk(idle_pulses == 0, "R7", idle_pulses, 0);
        cur_req = "R10";
        write_mode(8'h18 | 8'hC0);
        check_state("R10", 3, 0, 1);
        cur_req = "R7";
        pulse_in(0, 0, 1);
        check_state("R7", 2, 0, 1);
        measure("R10", 8, 0);

        cur_req = "R8";
        write_mode(8'h18 | 8'h40);
        write_mode(8'h10 | 8'h00);
        check_state("R8", 1, 1, 1);
        pulse_in(1, 1, 0);
        check_state("R8", 4, 0, 0);
        idle_pulses = 0;
        repeat (20) begin
            @(negedge clk);
            if (cpu_clk_en) idle_pulses++;
        end
        chk(idle_pulses == 0, "R8", idle_pulses, 0);
        pulse_in(0, 0, 1);
        check_state("R8", 1, 1, 1);
        measure("R8", 2, 1);

        cur_req = "R10";
        @(posedge clk); #1; mode_wr = 1'b1; mode_wdata = 8'h18; wait_req = 1'b1;
        @(posedge clk); #1; mode_wr = 1'b0; wait_req = 1'b0;
        check_state("R10", 3, 1, 1);
        pulse_in(0, 0, 1);
        check_state("R10", 1, 1, 1);

        cur_req = "R1";
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        check_state("R1", 0, 1, 1);
        measure("R1", 8, 0);

        done = 1'b1;
        finish_tb();
    end

endmodule